// File: doc/BRIEF.md
# Latched Bus Exchanger Between One A Port and Two B Banks

This block moves 12-bit words between a single A-side datapath and two B-side banks. In the A-to-B direction, one A word can be fanned out to bank 1, bank 2 or both. In the B-to-A direction, words from either bank are merged onto the single A path. Typical uses are splitting a shared address/data path into two buses, joining two such buses into one, and interleaving two memory banks.

Each direction has two level-sensitive storage latches, one per bank, and every latch has its own enable. A latch is transparent while its enable is high. It keeps the last word it passed once the enable goes low. On the A side, a bank select input picks which B-to-A latch feeds the A output.

Each port is modelled as an input bus, an output bus and a drive-enable bit. The three active-low output enables control drive for A, bank 1 and bank 2 independently. While a port is released, its drive-enable bit is low and its output bus is parked at zero. Output enables never touch the stored words.

Top module: `bus_exchanger`

## Requirements
- R1: While `ld_a2b1` is high and `drv_b1_n` is low, `b1_out` equals `a_in`, following every change of `a_in`.
- R2: While `ld_a2b2` is high and `drv_b2_n` is low, `b2_out` equals `a_in`.
- R3: When `ld_a2b1` or `ld_a2b2` goes low, that bank's stored word is the `a_in` value present just before the fall. It is held until the same enable goes high again, and the other bank's path is unaffected.
- R4: The B-to-A latches follow the same rule: `b1_in` is stored under `ld_b2a1` and `b2_in` under `ld_b2a2`, each transparent while high and holding while low.
- R5: With `drv_a_n` low, `a_out` carries the bank-1 B-to-A latch when `bank_sel` is 0 and the bank-2 latch when `bank_sel` is 1.
- R6: `a_oe` is 1 exactly when `drv_a_n` is 0. While `drv_a_n` is 1, `a_out` is all zeros.
- R7: `b1_oe` and `b2_oe` are 1 exactly when `drv_b1_n` and `drv_b2_n` respectively are 0. A released B bus is all zeros, and each bank is released independently of the other.
- R8: Releasing and re-enabling an output does not change any stored word. After re-enable, the port shows the word held before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 12 | Word arriving on the A side |
| a_out | output | 12 | Word driven onto the A side |
| a_oe | output | 1 | A side is driving |
| b1_in | input | 12 | Word arriving on bank 1 |
| b1_out | output | 12 | Word driven onto bank 1 |
| b1_oe | output | 1 | Bank 1 is driving |
| b2_in | input | 12 | Word arriving on bank 2 |
| b2_out | output | 12 | Word driven onto bank 2 |
| b2_oe | output | 1 | Bank 2 is driving |
| ld_a2b1 | input | 1 | Transparent-high enable, A-to-bank-1 latch |
| ld_a2b2 | input | 1 | Transparent-high enable, A-to-bank-2 latch |
| ld_b2a1 | input | 1 | Transparent-high enable, bank-1-to-A latch |
| ld_b2a2 | input | 1 | Transparent-high enable, bank-2-to-A latch |
| bank_sel | input | 1 | Selects the A output source: 0 bank 1, 1 bank 2 |
| drv_a_n | input | 1 | Active-low output enable for A |
| drv_b1_n | input | 1 | Active-low output enable for bank 1 |
| drv_b2_n | input | 1 | Active-low output enable for bank 2 |

## Verification
Two actions can land in the same step: a latch closing while its port is released, and a bank switch on the A side while the newly selected latch closes. The bench applies each pair in a single time step, then changes the data inputs. It then judges three things. The released port reads zero with its enable bit low. After re-enable, the port shows the word captured at the close. The A output shows the held word of the newly selected bank rather than live bank data.

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         ld_a2b1,
  input  logic         ld_a2b2,
  input  logic         ld_b2a1,
  input  logic         ld_b2a2,
  input  logic         bank_sel,
  input  logic         drv_a_n,
  input  logic         drv_b1_n,
  input  logic         drv_b2_n
);

  localparam logic [W-1:0] PARK = '0;

  logic [W-1:0] q_a2b1, q_a2b2, q_b2a1, q_b2a2;
  logic [W-1:0] a_pick;

  always_latch if (ld_a2b1) q_a2b1 = a_in;
  always_latch if (ld_a2b2) q_a2b2 = a_in;
  always_latch if (ld_b2a1) q_b2a1 = b1_in;
  always_latch if (ld_b2a2) q_b2a2 = b2_in;

  assign a_pick = bank_sel ? q_b2a2 : q_b2a1;

  assign a_oe  = ~drv_a_n;
  assign b1_oe = ~drv_b1_n;
  assign b2_oe = ~drv_b2_n;

  assign a_out  = a_oe  ? a_pick : PARK;
  assign b1_out = b1_oe ? q_a2b1 : PARK;
  assign b2_out = b2_oe ? q_a2b2 : PARK;

endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
  parameter int W = 12
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b1_out,
  input logic         b1_oe,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] b2_out,
  input logic         b2_oe,
  input logic         ld_a2b1,
  input logic         ld_a2b2,
  input logic         ld_b2a1,
  input logic         ld_b2a2,
  input logic         bank_sel,
  input logic         drv_a_n,
  input logic         drv_b1_n,
  input logic         drv_b2_n,
  input logic [W-1:0] q_a2b1,
  input logic [W-1:0] q_b2a2
);

  logic [3*W+7:0] stim;
  assign stim = {a_in, b1_in, b2_in, ld_a2b1, ld_a2b2, ld_b2a1, ld_b2a2,
                 bank_sel, drv_a_n, drv_b1_n, drv_b2_n};

  a_r1_pass_b1: assert property (@(stim)
    (ld_a2b1 === 1'b1 && drv_b1_n === 1'b0) |-> b1_out == a_in);

  a_r2_pass_b2: assert property (@(stim)
    (ld_a2b2 === 1'b1 && drv_b2_n === 1'b0) |-> b2_out == a_in);

  a_r3_hold_b1: assert property (@(stim)
    (ld_a2b1 === 1'b0 && $past(ld_a2b1) === 1'b0) |-> $stable(q_a2b1));

  a_r4_hold_b2a2: assert property (@(stim)
    (ld_b2a2 === 1'b0 && $past(ld_b2a2) === 1'b0) |-> $stable(q_b2a2));

  a_r5_sel_bank1: assert property (@(stim)
    (drv_a_n === 1'b0 && bank_sel === 1'b0 && ld_b2a1 === 1'b1) |-> a_out == b1_in);

  a_r5_sel_bank2: assert property (@(stim)
    (drv_a_n === 1'b0 && bank_sel === 1'b1 && ld_b2a2 === 1'b1) |-> a_out == b2_in);

  a_r6_a_park: assert property (@(stim)
    (drv_a_n === 1'b1) |-> (!a_oe && a_out == '0));

  a_r7_b_park: assert property (@(stim)
    (drv_b1_n === 1'b1 || drv_b2_n === 1'b1) |->
      ((drv_b1_n ? (!b1_oe && b1_out == '0) : b1_oe) &&
       (drv_b2_n ? (!b2_oe && b2_out == '0) : b2_oe)));

endmodule

bind bus_exchanger bus_exchanger_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bus_exchanger.sv
`timescale 1ns/1ps
module sim_bus_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;
  logic ld_a2b1, ld_a2b2, ld_b2a1, ld_b2a2, bank_sel;
  logic drv_a_n, drv_b1_n, drv_b2_n;

  int n_cmp = 0;
  int n_bad = 0;

  bus_exchanger #(.W(W)) u0 (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // R6 R7: everything released after power-on style setup
  task automatic t_released();
    step();
    drv_a_n = 1; drv_b1_n = 1; drv_b2_n = 1;
    ld_a2b1 = 1; ld_a2b2 = 1; ld_b2a1 = 1; ld_b2a2 = 1; bank_sel = 0;
    a_in = 12'h5A5; b1_in = 12'h111; b2_in = 12'h222;
    settle();
    chk("R6", {11'b0, a_oe}, 12'h0, "a_oe released");
    chk("R6", a_out, 12'h0, "a_out parked");
    chk("R7", {11'b0, b1_oe}, 12'h0, "b1_oe released");
    chk("R7", b1_out, 12'h0, "b1_out parked");
    chk("R7", b2_out, 12'h0, "b2_out parked");
  endtask

  // R1 R2: transparent fan-out to both banks
  task automatic t_pass_a2b();
    step();
    drv_b1_n = 0; drv_b2_n = 0; ld_a2b1 = 1; ld_a2b2 = 1;
    for (int i = 0; i < 4; i++) begin
      a_in = 12'h0F0 ^ (12'h123 * i[W-1:0]);
      settle();
      chk("R1", b1_out, a_in, "bank1 pass");
      chk("R2", b2_out, a_in, "bank2 pass");
      step();
    end
    chk("R7", {11'b0, b2_oe}, 12'h1, "b2_oe driving");
  endtask

  // R3: bank-1 latch closes, bank 2 keeps following
  task automatic t_hold_a2b();
    step();
    a_in = 12'hABC;
    step();
    ld_a2b1 = 0;
    step();
    a_in = 12'h321;
    settle();
    chk("R3", b1_out, 12'hABC, "bank1 holds");
    chk("R3", b2_out, 12'h321, "bank2 unaffected");
    step();
    ld_a2b1 = 1;
    settle();
    chk("R3", b1_out, 12'h321, "bank1 reopens");
    step();
    ld_a2b2 = 0;
    step();
    a_in = 12'h777;
    settle();
    chk("R3", b2_out, 12'h321, "bank2 holds");
    chk("R3", b1_out, 12'h777, "bank1 unaffected");
    step();
    ld_a2b2 = 1;
  endtask

  // R4 R5: B-to-A latches and bank select
  task automatic t_b2a();
    step();
    drv_a_n = 0; ld_b2a1 = 1; ld_b2a2 = 1;
    b1_in = 12'h1A1; b2_in = 12'h2B2; bank_sel = 0;
    settle();
    chk("R5", a_out, 12'h1A1, "sel0 bank1");
    chk("R6", {11'b0, a_oe}, 12'h1, "a_oe driving");
    step();
    bank_sel = 1;
    settle();
    chk("R5", a_out, 12'h2B2, "sel1 bank2");
    step();
    ld_b2a2 = 0;
    step();
    b2_in = 12'hFFF;
    settle();
    chk("R4", a_out, 12'h2B2, "bank2 to A holds");
    step();
    ld_b2a1 = 0;
    step();
    b1_in = 12'h000; bank_sel = 0;
    settle();
    chk("R4", a_out, 12'h1A1, "bank1 to A holds");
    step();
    ld_b2a1 = 1;
    settle();
    chk("R4", a_out, 12'h000, "bank1 to A reopens");
  endtask

  // R8: release and re-enable keep storage
  task automatic t_oe_keep();
    step();
    a_in = 12'h9C3; ld_a2b1 = 1;
    step();
    ld_a2b1 = 0;
    step();
    drv_b1_n = 1;
    step();
    a_in = 12'h046;
    settle();
    chk("R7", b1_out, 12'h0, "bank1 parked");
    chk("R7", b2_out, 12'h046, "bank2 still driving");
    step();
    drv_b1_n = 0;
    settle();
    chk("R8", b1_out, 12'h9C3, "bank1 word kept");
    step();
    ld_a2b1 = 1;
  endtask

  // Same-step events: close plus release, select switch plus close
  task automatic t_same_step();
    step();
    a_in = 12'h5C5; ld_a2b2 = 1;
    step();
    ld_a2b2 = 0; drv_b2_n = 1;
    step();
    a_in = 12'hE0E;
    settle();
    chk("R7", b2_out, 12'h0, "same step release");
    step();
    drv_b2_n = 0;
    settle();
    chk("R8", b2_out, 12'h5C5, "same step capture kept");
    step();
    ld_b2a2 = 1; b2_in = 12'h6D6; bank_sel = 0;
    step();
    bank_sel = 1; ld_b2a2 = 0;
    step();
    b2_in = 12'h0B0;
    settle();
    chk("R5", a_out, 12'h6D6, "switch and close");
    chk("R4", a_out, 12'h6D6, "bank2 to A held after switch");
    step();
    ld_a2b2 = 1; ld_b2a2 = 1;
  endtask

  initial begin
    fork
      begin
        t_released();
        t_pass_a2b();
        t_hold_a2b();
        t_b2a();
        t_oe_keep();
        t_same_step();
      end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule